// File: doc/BRIEF.md
# Serial Configuration Bitstream Source

This block stands in for a one-time-programmable serial memory that feeds a configuration bitstream to a loader one bit per clock. The bitstream lives in a read-only image given as a parameter. The loader supplies the clock and two control pins. The first is an active-low chip enable. The second is a combined reset and output-enable pin, and whether it is active high or active low is fixed when the block is built.

While either control pin holds the block off, the bit pointer is cleared at once, without waiting for a clock, and the data output is disabled. The output-enable flag stands in for the high-impedance state. Chip enable high also reports standby. Once both pins let go, a short release synchronizer runs first. After that, each rising clock edge presents the next bit of the image, starting at bit 0. When the last bit has been shown, the pointer stops rather than wrapping. From then on the output reads a steady 1.

Top module: `scp_emu`

## Requirements
- R1: Parameter RESET_ACTIVE_LOW picks the polarity of `rst_oe`. With 0, a high level on the pin is the reset state. With 1, a low level is the reset state. Both builds behave the same for the same logical reset.
- R2: While reset is active, `sdata_oe` is 0 and the bit pointer is held at 0. This takes effect in the same cycle the pin changes, with no clock edge needed.
- R3: While `ce_n` is 1, `standby` is 1, `sdata_oe` is 0 and the bit pointer is held at 0, whatever level `rst_oe` has. While `ce_n` is 0, `standby` is 0.
- R4: After reset and chip enable both release, the first two rising edges present nothing and `sdata_oe` stays 0. The third edge presents image bit 0 and raises `sdata_oe`.
- R5: Each later rising edge presents the next bit. The k-th bit shown is bit k of ROM_IMAGE, counted from the least significant bit.
- R6: Once bit DEPTH_BITS-1 has been shown, further edges leave the pointer where it is and never wrap. They present a constant 1 with `sdata_oe` still 1.
- R7: `sdata` is 0 whenever `sdata_oe` is 0.
- R8: A reset or chip-enable pulse of any length, even in the middle of the stream or after its end, restarts the stream from bit 0 with the same two-edge lead-in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock from the loader |
| ce_n | input | 1 | Chip enable, active low; high clears the pointer and enters standby |
| rst_oe | input | 1 | Combined reset and output enable; polarity set by RESET_ACTIVE_LOW |
| sdata | output | 1 | Serial bitstream output, 0 while disabled |
| sdata_oe | output | 1 | High when `sdata` is driven; low stands for high impedance |
| standby | output | 1 | High while chip enable is inactive |

## Verification
Long uninterrupted runs walk the whole image and go past its end. A wrong bit order, an off-by-one in the pointer or a wrap at the end shows up as a wrong bit or a missing constant 1 in these runs. Random short pulses on reset and on chip enable land at arbitrary points in the stream. They show whether a restart really goes back to bit 0 and whether the two-edge lead-in is kept. Each change of the control pins is checked once before the next clock edge, so a clear that waits for a clock is caught. Two builds, one of each reset polarity, receive the same stimulus with opposite pin levels, which separates a polarity error from every other fault.

// File: rtl/scp_pkg.sv
package scp_pkg;
  // Decode the combined reset/output-enable pin into an active-high reset.
  function automatic logic rst_decode(input logic pin, input bit active_low);
    return active_low ? ~pin : pin;
  endfunction
endpackage

// File: rtl/scp_release_sync.sv
module scp_release_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  output logic run
);
  logic [STAGES-1:0] stage_q, stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign run = stage_q[STAGES-1];
endmodule

// File: rtl/scp_addr_ctr.sv
module scp_addr_ctr #(
  parameter int DEPTH_BITS = 64,
  localparam int CW = $clog2(DEPTH_BITS + 1)
) (
  input  logic          clk,
  input  logic          clr_n,
  input  logic          run,
  output logic [CW-1:0] addr,
  output logic          cnt_en
);
  localparam logic [CW-1:0] END_PTR = CW'(DEPTH_BITS);

  logic [CW-1:0] addr_q, addr_d;
  logic          at_end;

  assign at_end = (addr_q == END_PTR);
  assign cnt_en = run & ~at_end;

  always_comb begin
    addr_d = addr_q;
    if (cnt_en) addr_d = addr_q + CW'(1);
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr = addr_q;
endmodule

// File: rtl/scp_bit_rom.sv
module scp_bit_rom #(
  parameter int                    DEPTH_BITS = 64,
  parameter logic [DEPTH_BITS-1:0] IMAGE      = '0,
  localparam int CW = $clog2(DEPTH_BITS + 1),
  localparam int IW = (DEPTH_BITS > 1) ? $clog2(DEPTH_BITS) : 1
) (
  input  logic [CW-1:0] addr,
  output logic          bit_o
);
  logic [IW-1:0] idx;

  always_comb begin
    idx   = IW'(addr);
    bit_o = 1'b1;
    if (addr < CW'(DEPTH_BITS)) bit_o = IMAGE[idx];
  end
endmodule

// File: rtl/scp_emu.sv
module scp_emu #(
  parameter int                    DEPTH_BITS       = 64,
  parameter bit                    RESET_ACTIVE_LOW = 1'b0,
  parameter int                    SYNC_STAGES      = 2,
  parameter logic [DEPTH_BITS-1:0] ROM_IMAGE        = 64'hC3A5_1F0E_96D2_7B48
) (
  input  logic clk,
  input  logic ce_n,
  input  logic rst_oe,
  output logic sdata,
  output logic sdata_oe,
  output logic standby
);
  import scp_pkg::*;

  localparam int CW = $clog2(DEPTH_BITS + 1);

  logic          rst_act, hold, clr_n, run, cnt_en, rom_bit;
  logic [CW-1:0] addr;
  logic          dat_q, dat_d, vld_q, vld_d;

  assign rst_act = rst_decode(rst_oe, RESET_ACTIVE_LOW);
  assign hold    = rst_act | ce_n;
  assign clr_n   = ~hold;

  scp_release_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .clr_n(clr_n), .run(run)
  );

  scp_addr_ctr #(.DEPTH_BITS(DEPTH_BITS)) u_ctr (
    .clk(clk), .clr_n(clr_n), .run(run), .addr(addr), .cnt_en(cnt_en)
  );

  scp_bit_rom #(.DEPTH_BITS(DEPTH_BITS), .IMAGE(ROM_IMAGE)) u_rom (
    .addr(addr), .bit_o(rom_bit)
  );

  always_comb begin
    dat_d = dat_q;
    vld_d = vld_q;
    if (run) begin
      dat_d = rom_bit;
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      dat_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      dat_q <= dat_d;
      vld_q <= vld_d;
    end
  end

  assign sdata_oe = vld_q & ~hold;
  assign sdata    = dat_q & sdata_oe;
  assign standby  = ce_n;
endmodule

// File: rtl/scp_emu_chk.sv
module scp_emu_chk #(
  parameter int DEPTH_BITS = 64,
  parameter int CW         = 7
) (
  input logic          clk,
  input logic          hold,
  input logic          ce_n,
  input logic          rst_act,
  input logic [CW-1:0] addr,
  input logic          cnt_en,
  input logic          sdata_oe,
  input logic          standby
);
  localparam logic [CW-1:0] END_PTR = CW'(DEPTH_BITS);

  // R2
  rst_clears_chk: assert property (@(posedge clk) rst_act |-> (addr == '0) && !sdata_oe);

  // R3
  standby_chk: assert property (@(posedge clk) ce_n |-> standby && !sdata_oe && (addr == '0));

  // R4
  lead_in_chk: assert property (@(posedge clk) disable iff (hold) $past(hold) |-> !sdata_oe);

  // R5
  step_chk: assert property (@(posedge clk) disable iff (hold)
    (cnt_en && !$past(hold)) |=> (addr == $past(addr) + CW'(1)));

  // R6
  end_hold_chk: assert property (@(posedge clk) disable iff (hold) (addr == END_PTR) |=> (addr == END_PTR));

  // R6
  no_wrap_chk: assert property (@(posedge clk) addr <= END_PTR);
endmodule

bind scp_emu scp_emu_chk #(.DEPTH_BITS(DEPTH_BITS), .CW(CW)) u_chk (
  .clk(clk), .hold(hold), .ce_n(ce_n), .rst_act(rst_act), .addr(addr),
  .cnt_en(cnt_en), .sdata_oe(sdata_oe), .standby(standby)
);

// File: tb/scp_emu_test.sv
module scp_emu_test;
  localparam int              PERIOD = 10;
  localparam int              D      = 64;
  localparam logic [D-1:0]    IMG    = 64'h9B3C_E071_5AD2_486F;

  logic clk = 1'b0;
  logic ce_n, rst_hi, rst_lo;
  logic sd_a, oe_a, sb_a, sd_b, oe_b, sb_b;

  int total = 0;
  int bad   = 0;

  // model state
  int   rel = 0;
  int   maddr = 0;
  logic mdata = 1'b0, mvalid = 1'b0, mpast = 1'b0, restarted = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  scp_emu #(.DEPTH_BITS(D), .ROM_IMAGE(IMG)) uut (
    .clk(clk), .ce_n(ce_n), .rst_oe(rst_hi),
    .sdata(sd_a), .sdata_oe(oe_a), .standby(sb_a)
  );

  scp_emu #(.DEPTH_BITS(D), .RESET_ACTIVE_LOW(1'b1), .ROM_IMAGE(IMG)) uut_lo (
    .clk(clk), .ce_n(ce_n), .rst_oe(rst_lo),
    .sdata(sd_b), .sdata_oe(oe_b), .standby(sb_b)
  );

  function automatic string ctx_tag(input logic r, input logic c);
    if (c)            return "R3";
    if (r)            return "R2";
    if (!mvalid)      return "R4";
    if (mpast)        return "R6";
    if (restarted)    return "R8";
    return "R5";
  endfunction

  task automatic check_one(input string tag, input logic sd, input logic oe, input logic sb,
                           input logic esd, input logic eoe, input logic esb);
    total++;
    if (sd !== esd || oe !== eoe || sb !== esb) begin
      bad++;
      $display("FAIL %s: got sdata=%b oe=%b standby=%b, expected sdata=%b oe=%b standby=%b at %0t",
               tag, sd, oe, sb, esd, eoe, esb, $time);
    end
    total++;
    if (!oe && sd !== 1'b0) begin
      bad++;
      $display("FAIL R7: got sdata=%b with oe=0, expected sdata=0 at %0t", sd, $time);
    end
  endtask

  task automatic compare();
    logic r, c, eoe, esd;
    r   = rst_hi;
    c   = ce_n;
    eoe = mvalid & ~(r | c);
    esd = eoe ? mdata : 1'b0;
    check_one(ctx_tag(r, c), sd_a, oe_a, sb_a, esd, eoe, c);
    // R1: active-low build driven with inverted pin must match
    check_one("R1", sd_b, oe_b, sb_b, esd, eoe, c);
  endtask

  task automatic cycle(input logic r, input logic c);
    compare();
    rst_hi = r;
    rst_lo = ~r;
    ce_n   = c;
    if (r | c) begin
      if (mvalid || rel > 0) restarted = 1'b1;
      rel = 0; maddr = 0; mvalid = 1'b0; mdata = 1'b0; mpast = 1'b0;
    end
    #1;
    compare();   // R2 R3: clearing needs no clock
    @(posedge clk);
    if (!(r | c)) begin
      if (rel == 2) begin
        mvalid = 1'b1;
        mpast  = (maddr >= D);
        mdata  = (maddr < D) ? IMG[maddr] : 1'b1;
        if (maddr < D) maddr++;
      end else begin
        rel++;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_hi = 1'b1; rst_lo = 1'b0; ce_n = 1'b0;
    @(negedge clk);
    // R2 reset state
    for (int i = 0; i < 4; i++) cycle(1'b1, 1'b0);
    // R4 R5 R6: full stream and beyond
    for (int i = 0; i < D + 10; i++) cycle(1'b0, 1'b0);
    // R3 standby while reset pin idle, then restart (R8)
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1);
    for (int i = 0; i < 20; i++) cycle(1'b0, 1'b0);
    // both active, then each alone, single-cycle pulses
    cycle(1'b1, 1'b1);
    cycle(1'b0, 1'b1);
    cycle(1'b1, 1'b0);
    for (int i = 0; i < 6; i++) cycle(1'b0, 1'b0);
    cycle(1'b1, 1'b0);
    for (int i = 0; i < D + 6; i++) cycle(1'b0, 1'b0);
    // R8: pulse after the end of the stream
    cycle(1'b0, 1'b1);
    for (int i = 0; i < 10; i++) cycle(1'b0, 1'b0);
    // random pulses, dense then sparse
    for (int i = 0; i < 3000; i++)
      cycle(($urandom % 24) == 0, ($urandom % 24) == 0);
    for (int i = 0; i < 4000; i++)
      cycle(($urandom % 150) == 0, ($urandom % 150) == 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule